// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial slave protocol engine of a byte-addressed nonvolatile memory. When a write command arrives it receives the start address and then a stream of data bytes. It keeps the bytes in a page-sized latch that also holds one valid bit per byte. A column pointer covers only the low address bits, so bytes sent past the end of a row wrap back to the start of that same row and replace bytes latched earlier. The row, meaning the address bits above the column, is taken from the start address and does not change during the command.

When the protocol engine reports a Stop, it also says whether that Stop came right after the acknowledge slot of a data byte. Only such a Stop, with at least one byte latched, starts an internal write cycle. During that cycle `busy` is high for `WRITE_CYCLES` clocks. In the last `PAGE_BYTES` of those clocks the sequencer walks the columns in ascending order and writes every marked byte to the array port, one column per clock. Any other Stop, a Start, or a new address load throws the latched page away. A single-byte write is simply a page write of one byte.

Data bytes arrive on a valid/ready stream. A byte is taken on a clock where `din_valid` and `din_ready` are both high. `din_ready` is low for the whole internal write cycle, and the producer holds `din_valid` and `din_data` steady until the byte is taken. The control pulses `start`, `addr_load` and `stop` are plain one-clock strobes.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset `busy` is low, `din_ready` is high and `arr_we` is low.
- R2: A byte taken while `write_protect` is low is latched at the current column. The column starts at the low 6 bits of `addr_in` (bits 5:0) and advances by one, modulo 64, for every byte taken. A later byte at the same column replaces the earlier one.
- R3: A byte taken while `write_protect` is high is not written to the array, but it still advances the column.
- R4: An internal write cycle starts only on a `stop` pulse with `stop_after_ack` high while at least one byte is latched. Any other `stop` starts no cycle and discards the latched page.
- R5: `busy` rises in the clock after the launching `stop` and stays high for exactly `WRITE_CYCLES` clocks. It falls in the clock after the last commit slot.
- R6: In the last `PAGE_BYTES` clocks of `busy`, column c is presented in commit slot c, so the columns come in ascending order. `arr_we` is high only for latched columns. `arr_addr` is {row, column}, where the row is `addr_in` bits 14:6 from the load, and `arr_wdata` is the latched byte.
- R7: While `busy` is high, `din_ready` is low. Incoming `start`, `addr_load`, `stop` and data have no effect, and the page being committed is unchanged.
- R8: A `start` pulse or a new `addr_load` with no launching Stop in between discards every byte latched before it.
- R9: A command carrying a single byte commits exactly that one byte at its address.
- R10: After a commit the page latch is empty, so a following launching-type `stop` with no new bytes starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start condition seen (one-clock pulse) |
| addr_load | input | 1 | Start address valid (one-clock pulse) |
| addr_in | input | ADDR_W | Start address of the write command |
| write_protect | input | 1 | High: incoming data bytes are refused |
| din_valid | input | 1 | Data byte offered |
| din_ready | output | 1 | Data byte can be taken (low while busy) |
| din_data | input | 8 | Data byte |
| stop | input | 1 | Stop condition seen (one-clock pulse) |
| stop_after_ack | input | 1 | Qualifies `stop`: it came right after a data acknowledge slot |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions assume the protocol engine never sends `start`, `addr_load`, `stop` and an accepted byte in the same clock. They also assume that `stop_after_ack` has meaning only together with `stop`. The stimulus tasks drive each strobe on its own clock, lowered one clock later, and send bytes only after the address load and before the Stop. The one place where the bench knowingly breaks these rules is inside an active write cycle, where it raises every strobe at once to show that they are ignored.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_HOLD   = 2'd1,
    SQ_COMMIT = 2'd2
  } seq_state_t;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pwb_col_tracker.sv
module pwb_col_tracker #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              advance,
  output logic [ADDR_W-COL_W-1:0] row,
  output logic [COL_W-1:0]  col
);
  localparam int unsigned ROW_W = ADDR_W - COL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (load) begin
      row <= addr_in[ADDR_W-1:COL_W];
      col <= addr_in[COL_W-1:0];
    end else if (advance) begin
      col <= col + COL_W'(1);   // wraps inside the row
    end
  end

  generate
    if (ROW_W < 1) begin : g_bad_width
      $error("address must be wider than the column field");
    end
  endgenerate
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned COL_W      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [COL_W-1:0]           wr_col,
  input  logic [pwb_pkg::BYTE_W-1:0] wr_data,
  input  logic [COL_W-1:0]           rd_col,
  output logic [pwb_pkg::BYTE_W-1:0] rd_data,
  output logic                       rd_marked,
  output logic                       any_marked
);
  logic [pwb_pkg::BYTE_W-1:0] slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]      mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
    end else if (clr) begin
      mark_q <= '0;
    end else if (wr_en) begin
      mark_q[wr_col] <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && !clr && (wr_col == COL_W'(i))) begin
          slot_q[i] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data    = slot_q[rd_col];
  assign rd_marked  = mark_q[rd_col];
  assign any_marked = |mark_q;
endmodule

// File: rtl/pwb_write_seq.sv
module pwb_write_seq #(
  parameter int unsigned PAGE_BYTES   = 64,
  parameter int unsigned COL_W        = 6,
  parameter int unsigned WRITE_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy,
  output logic             scan_en,
  output logic [COL_W-1:0] scan_col,
  output logic             done
);
  import pwb_pkg::*;

  localparam int unsigned HOLD_CYCLES = WRITE_CYCLES - PAGE_BYTES;
  localparam int unsigned CNT_MAX     = (HOLD_CYCLES > PAGE_BYTES) ? HOLD_CYCLES : PAGE_BYTES;
  localparam int unsigned CNT_W       = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_LAST = CNT_W'(PAGE_BYTES - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (WRITE_CYCLES <= PAGE_BYTES) begin : g_bad_cycles
      $error("WRITE_CYCLES must exceed PAGE_BYTES");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (launch) state_q <= SQ_HOLD;
        end
        SQ_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            state_q <= SQ_COMMIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        SQ_COMMIT: begin
          if (cnt_q == SCAN_LAST) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_q <= SQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign scan_en  = (state_q == SQ_COMMIT);
  assign scan_col = cnt_q[COL_W-1:0];
  assign done     = (state_q == SQ_COMMIT) && (cnt_q == SCAN_LAST);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned PAGE_BYTES   = 64,
  parameter int unsigned WRITE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              write_protect,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  input  logic              stop,
  input  logic              stop_after_ack,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int unsigned COL_W = $clog2(PAGE_BYTES);
  localparam int unsigned ROW_W = ADDR_W - COL_W;

  logic             take;
  logic             latch_en;
  logic             launch;
  logic             discard;
  logic             page_clr;
  logic             any_marked;
  logic             rd_marked;
  logic             scan_en;
  logic             seq_done;
  logic [COL_W-1:0] col;
  logic [COL_W-1:0] scan_col;
  logic [ROW_W-1:0] row;
  logic [7:0]       rd_data;

  assign din_ready = !busy;
  assign take      = din_valid && din_ready;
  assign latch_en  = take && !write_protect;
  assign launch    = !busy && stop && stop_after_ack && any_marked;
  assign discard   = !busy && (start || addr_load || (stop && !launch));
  assign page_clr  = discard || seq_done;

  pwb_col_tracker #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W)
  ) u_cols (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (addr_load && !busy),
    .addr_in (addr_in),
    .advance (take),
    .row     (row),
    .col     (col)
  );

  pwb_page_store #(
    .PAGE_BYTES (PAGE_BYTES),
    .COL_W      (COL_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (page_clr),
    .wr_en      (latch_en),
    .wr_col     (col),
    .wr_data    (din_data),
    .rd_col     (scan_col),
    .rd_data    (rd_data),
    .rd_marked  (rd_marked),
    .any_marked (any_marked)
  );

  pwb_write_seq #(
    .PAGE_BYTES   (PAGE_BYTES),
    .COL_W        (COL_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .busy     (busy),
    .scan_en  (scan_en),
    .scan_col (scan_col),
    .done     (seq_done)
  );

  assign arr_we    = scan_en && rd_marked;
  assign arr_addr  = {row, scan_col};
  assign arr_wdata = rd_data;
endmodule

// File: rtl/pwb_page_writer_chk.sv
module pwb_page_writer_chk #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PAGE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              stop_after_ack,
  input logic              din_ready,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int unsigned COL_W = $clog2(PAGE_BYTES);

  // R7: no byte can be taken during a write cycle
  a_r7_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !din_ready);

  // R6: array writes happen only inside a write cycle
  a_r6_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R2: the row stays fixed for the whole cycle
  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:COL_W]));

  // R4: a cycle begins only after a qualified stop
  a_r4_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop && stop_after_ack));

  // R6: the column advances by one on every clock of the commit window
  a_r6_col_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(busy) && $past(arr_we)) |->
      (arr_addr[COL_W-1:0] == $past(arr_addr[COL_W-1:0]) + COL_W'(1)));
endmodule

bind pwb_page_writer pwb_page_writer_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop           (stop),
  .stop_after_ack (stop_after_ack),
  .din_ready      (din_ready),
  .busy           (busy),
  .arr_we         (arr_we),
  .arr_addr       (arr_addr)
);

// File: tb/test_pwb_page_writer.sv
module test_pwb_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 15;
  localparam int PG  = 64;
  localparam int WC  = 100;
  localparam int NVEC = 7;

  // {addr[24:10], byte count[9:2], write_protect[1], stop_after_ack[0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {15'h0000, 8'd1,  1'b0, 1'b1},  // R9 single byte
    {15'h0045, 8'd64, 1'b0, 1'b1},  // R2 full page from mid-row, wraps
    {15'h7FFC, 8'd8,  1'b0, 1'b1},  // R2 wrap past row end
    {15'h0100, 8'd70, 1'b0, 1'b1},  // R2 overwrite by wrap
    {15'h0200, 8'd5,  1'b1, 1'b1},  // R3 protected, nothing latched
    {15'h0300, 8'd4,  1'b0, 1'b0},  // R4 stop in wrong slot
    {15'h0123, 8'd3,  1'b0, 1'b1}   // R6 sparse page
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, addr_load = 1'b0, write_protect = 1'b0;
  logic din_valid = 1'b0, stop = 1'b0, stop_after_ack = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] din_data = '0;
  logic din_ready, busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  int checks = 0;
  int fails  = 0;

  // capture of one write cycle
  logic [7:0]    cap_d [PG];
  logic [PG-1:0] cap_m;
  int            busy_cnt;
  int            row_bad;
  int            dup_cnt;
  logic [AW-7:0] exp_row;
  logic [7:0]    exp_d [PG];
  logic [PG-1:0] exp_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) i_pwb_page_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_load(addr_load), .addr_in(addr_in),
    .write_protect(write_protect), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .stop(stop), .stop_after_ack(stop_after_ack), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (arr_we) begin
      if (cap_m[arr_addr[5:0]]) dup_cnt++;
      cap_m[arr_addr[5:0]] = 1'b1;
      cap_d[arr_addr[5:0]] = arr_wdata;
      if (arr_addr[AW-1:6] != exp_row) row_bad++;
    end
  end

  function automatic logic [7:0] dval(int v, int k);
    return 8'(k * 7 + v * 31 + 3);
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_cap();
    cap_m = '0; busy_cnt = 0; row_bad = 0; dup_cnt = 0; exp_m = '0;
    for (int i = 0; i < PG; i++) begin cap_d[i] = '0; exp_d[i] = '0; end
  endtask

  task automatic send_cmd(logic [AW-1:0] a, int n, logic wp, int v, logic do_start);
    if (do_start) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    @(negedge clk) begin addr_load = 1'b1; addr_in = a; end
    @(negedge clk) begin addr_load = 1'b0; write_protect = wp; end
    for (int k = 0; k < n; k++) begin
      din_valid = 1'b1; din_data = dval(v, k);
      @(negedge clk);
    end
    din_valid = 1'b0; write_protect = 1'b0;
  endtask

  task automatic send_stop(logic ok);
    stop = 1'b1; stop_after_ack = ok;
    @(negedge clk) begin stop = 1'b0; stop_after_ack = 1'b0; end
    repeat (WC + 4) @(negedge clk);
  endtask

  task automatic compare_page(string req, int launched);
    int mism = 0;
    check(req, "busy cycles", busy_cnt, launched ? WC : 0);
    check(req, "committed mask", (cap_m == exp_m) ? 1 : 0, 1);
    for (int i = 0; i < PG; i++) if (exp_m[i] && cap_d[i] != exp_d[i]) mism++;
    check(req, "data mismatches", mism, 0);
    check(req, "row errors", row_bad + dup_cnt, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_cap();
    exp_row = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "din_ready", din_ready, 1);
    check("R1", "arr_we", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven commands
    for (int v = 0; v < NVEC; v++) begin
      logic [AW-1:0] a;
      int n;
      logic wp, ok;
      a = VEC[v][24:10]; n = int'(VEC[v][9:2]); wp = VEC[v][1]; ok = VEC[v][0];
      send_cmd(a, n, wp, v, 1'b1);
      clear_cap();
      exp_row = a[AW-1:6];
      if (!wp) for (int k = 0; k < n; k++) begin
        exp_d[(int'(a[5:0]) + k) % PG] = dval(v, k);
        exp_m[(int'(a[5:0]) + k) % PG] = 1'b1;
      end
      if (!ok) exp_m = '0;
      if (wp) exp_m = '0;
      send_stop(ok);
      compare_page(v == 0 ? "R9" : (wp ? "R3" : (!ok ? "R4" : "R2/R5/R6")),
                   (ok && !wp && n > 0) ? 1 : 0);
    end

    // R3 column still advances: 2 protected then 1 open byte
    send_cmd(15'h0410, 2, 1'b1, 20, 1'b1);
    send_cmd(15'h0410, 0, 1'b0, 20, 1'b0);
    clear_cap();
    exp_row = 9'h010;
    @(negedge clk);
    // re-issue: load, 2 protected bytes, 1 open byte without reload
    addr_load = 1'b1; addr_in = 15'h0410;
    @(negedge clk) begin addr_load = 1'b0; write_protect = 1'b1; din_valid = 1'b1; din_data = 8'h11; end
    @(negedge clk) din_data = 8'h22;
    @(negedge clk) begin write_protect = 1'b0; din_data = 8'h33; end
    @(negedge clk) din_valid = 1'b0;
    exp_m = '0; exp_m[18] = 1'b1; exp_d[18] = 8'h33;
    send_stop(1'b1);
    compare_page("R3", 1);

    // R8 start discards latched bytes
    send_cmd(15'h0600, 3, 1'b0, 30, 1'b1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    clear_cap();
    send_stop(1'b1);
    check("R8", "busy after start-discard", busy_cnt, 0);

    // R8 new address load discards earlier bytes
    send_cmd(15'h0640, 2, 1'b0, 31, 1'b1);
    send_cmd(15'h0650, 1, 1'b0, 32, 1'b0);
    clear_cap();
    exp_row = 9'h019; exp_m[16] = 1'b1; exp_d[16] = dval(32, 0);
    send_stop(1'b1);
    compare_page("R8", 1);

    // R7 strobes during busy are ignored; R10 latch empty afterwards
    send_cmd(15'h0400, 2, 1'b0, 40, 1'b1);
    clear_cap();
    exp_row = 9'h010;
    exp_m[0] = 1'b1; exp_m[1] = 1'b1; exp_d[0] = dval(40, 0); exp_d[1] = dval(40, 1);
    stop = 1'b1; stop_after_ack = 1'b1;
    @(negedge clk) begin stop = 1'b0; stop_after_ack = 1'b0; end
    repeat (5) @(negedge clk);
    check("R7", "din_ready while busy", din_ready, 0);
    start = 1'b1; addr_load = 1'b1; addr_in = 15'h0555; stop = 1'b1; stop_after_ack = 1'b1;
    din_valid = 1'b1; din_data = 8'hEE;
    @(negedge clk) begin
      start = 1'b0; addr_load = 1'b0; stop = 1'b0; stop_after_ack = 1'b0;
    end
    @(negedge clk) din_valid = 1'b0;
    repeat (WC + 4) @(negedge clk);
    compare_page("R7", 1);
    clear_cap();
    @(negedge clk);
    send_stop(1'b1);
    check("R10", "busy with empty latch", busy_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule